// File: doc/BRIEF.md
# Power-Up Strap Capture Sequencer

This block manages two shared pins that start life as configuration inputs and later carry clock outputs. When the supply-good indication rises, the sequencer keeps both pin drivers switched off for a fixed number of clock cycles. During that time the external pull resistors alone set each pin level. When the window closes, the synchronized pin levels are stored once and a done flag rises. One cycle after that, both drivers are switched on so that the pins start carrying clocks.

The first pin (the reference pin) stores a bit that selects the rate of the clock on the second pin. The second pin stores the upper frequency-select bit. The stored bits stay fixed for as long as the supply stays good. Only a loss of power_good clears them, and the next rise of power_good starts a fresh sampling pass.

Top module: `strap_sampler`

## Requirements
- R1: Call the first rising clock edge with power_good high edge 1. The window then lasts WINDOW_CYCLES cycles, and `done` rises at edge WINDOW_CYCLES+2. It is low after every earlier edge.
- R2: While `done` is low, `oe_ref` and `oe_alt` are both low, so both pins stay three-stated.
- R3: `strap_ref` stores the level of `pin_ref_lvl` and `strap_fs1` stores the level of `pin_alt_lvl`, with low giving 0 and high giving 1. The level stored is the one present at edge WINDOW_CYCLES, because each pin passes through two synchronizer flops. Pin changes before that edge have no effect.
- R4: `oe_ref` and `oe_alt` both rise exactly one clock cycle after `done` rises.
- R5: While power_good stays high after `done`, pin changes have no effect. `strap_ref`, `strap_fs1`, `done` and both enables hold their values, and no second capture takes place.
- R6: When power_good is low, `done`, both enables and both strap bits are 0 without waiting for a clock edge. The next rise of power_good starts a new window and a new capture.
- R7: `alt_is_24m` is 0 when the stored reference strap is 0, which means the second pin carries 48 MHz. It is 1 when the stored reference strap is 1, which means the second pin carries 24 MHz.
- R8: Before power_good has ever risen, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| power_good | input | 1 | Supply-above-threshold flag; low acts as asynchronous clear |
| pin_ref_lvl | input | 1 | Level seen on the reference pin |
| pin_alt_lvl | input | 1 | Level seen on the second shared pin |
| oe_ref | output | 1 | Driver enable for the reference pin |
| oe_alt | output | 1 | Driver enable for the second shared pin |
| strap_ref | output | 1 | Stored reference-pin strap |
| strap_fs1 | output | 1 | Stored frequency-select bit from the second pin |
| alt_is_24m | output | 1 | Second pin rate: 1 gives 24 MHz, 0 gives 48 MHz |
| done | output | 1 | Capture complete |

## Verification
The hardest case to reach is the exact capture instant. The stored value must reflect the pin level at one particular edge near the end of the window, and none of the levels that came before it. The stimulus therefore toggles both pins randomly until one cycle before that edge, then settles them at a chosen value and compares the stored bits with it. Separately, power_good is dropped at random points inside and after the window, and pins are toggled after capture, to show that the bits are neither kept across a power loss nor re-sampled while the supply stays up.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WINDOW  = 2'd1,
    ST_CAPTURE = 2'd2,
    ST_DRIVE   = 2'd3
  } seq_state_t;

  // Second pin runs at half rate (24 MHz) when the reference strap is high.
  function automatic logic alt_half_rate(input logic ref_strap);
    return ref_strap;
  endfunction

  // Clock edges after power_good rises until done is set.
  function automatic int unsigned edges_to_done(input int unsigned win);
    return win + 32'd2;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned NPINS  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_sync
);

  logic [NPINS-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign pin_sync = stage_q[STAGES-1];

endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
  parameter int unsigned CYCLES = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (!expire) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && (cnt_q == LAST);

endmodule

// File: rtl/strap_seq.sv
module strap_seq
  import strap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic win_expire,
  output logic win_run,
  output logic capture_evt,
  output logic done_q,
  output logic drive_q
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    state_d = ST_WINDOW;
      ST_WINDOW:  if (win_expire) state_d = ST_CAPTURE;
      ST_CAPTURE: state_d = ST_DRIVE;
      ST_DRIVE:   state_d = ST_DRIVE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign win_run     = (state_q == ST_WINDOW);
  assign capture_evt = (state_q == ST_CAPTURE);

  // done is set by the capture edge; drivers follow one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      if (capture_evt) done_q <= 1'b1;
      drive_q <= done_q;
    end
  end

endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pkg::*;
#(
  parameter int unsigned WINDOW_CYCLES = 400000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic power_good,
  input  logic pin_ref_lvl,
  input  logic pin_alt_lvl,
  output logic oe_ref,
  output logic oe_alt,
  output logic strap_ref,
  output logic strap_fs1,
  output logic alt_is_24m,
  output logic done
);

  localparam int unsigned NPINS = 2;
  localparam int unsigned IDX_REF = 0;
  localparam int unsigned IDX_ALT = 1;

  logic [NPINS-1:0] pins_raw, pins_sync, straps_q;
  logic win_run, window_expire, capture_evt, done_q, drive_q;

  assign pins_raw[IDX_REF] = pin_ref_lvl;
  assign pins_raw[IDX_ALT] = pin_alt_lvl;

  strap_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(power_good), .pin_in(pins_raw), .pin_sync(pins_sync)
  );

  strap_window_timer #(.CYCLES(WINDOW_CYCLES)) u_timer (
    .clk(clk), .rst_n(power_good), .run(win_run), .expire(window_expire)
  );

  strap_seq u_seq (
    .clk(clk), .rst_n(power_good), .win_expire(window_expire),
    .win_run(win_run), .capture_evt(capture_evt),
    .done_q(done_q), .drive_q(drive_q)
  );

  genvar i;
  generate
    for (i = 0; i < NPINS; i++) begin : g_latch
      always_ff @(posedge clk or negedge power_good) begin
        if (!power_good)      straps_q[i] <= 1'b0;
        else if (capture_evt) straps_q[i] <= pins_sync[i];
      end
    end
  endgenerate

  assign strap_ref  = straps_q[IDX_REF];
  assign strap_fs1  = straps_q[IDX_ALT];
  assign alt_is_24m = alt_half_rate(straps_q[IDX_REF]);
  assign done       = done_q;
  assign oe_ref     = drive_q;
  assign oe_alt     = drive_q;

endmodule

// File: rtl/strap_sampler_chk.sv
module strap_sampler_chk #(
  parameter int unsigned WINDOW_CYCLES = 400000
) (
  input logic clk,
  input logic power_good,
  input logic done,
  input logic oe_ref,
  input logic oe_alt,
  input logic strap_ref,
  input logic strap_fs1,
  input logic capture_evt
);

  localparam logic [31:0] DONE_AT = 32'(WINDOW_CYCLES + 1);

  logic [31:0] since_pg;

  always_ff @(posedge clk or negedge power_good) begin
    if (!power_good)                       since_pg <= '0;
    else if (!done && since_pg != '1)      since_pg <= since_pg + 1'b1;
  end

  AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (!power_good)
    (since_pg == DONE_AT) |=> done); // R1
  AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!power_good)
    (since_pg < DONE_AT) |=> !done); // R1
  AST_OE_GATED: assert property (@(posedge clk) disable iff (!power_good)
    !done |-> (!oe_ref && !oe_alt)); // R2
  AST_OE_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!power_good)
    (done && !oe_ref) |=> (oe_ref && oe_alt)); // R4
  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!power_good)
    done |=> (done && $stable({strap_ref, strap_fs1}))); // R5
  AST_SINGLE_CAPTURE: assert property (@(posedge clk) disable iff (!power_good)
    capture_evt |-> !done); // R5

endmodule

bind strap_sampler strap_sampler_chk #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_chk (
  .clk(clk), .power_good(power_good), .done(done), .oe_ref(oe_ref),
  .oe_alt(oe_alt), .strap_ref(strap_ref), .strap_fs1(strap_fs1),
  .capture_evt(capture_evt)
);

// File: tb/strap_sampler_bench.sv
module strap_sampler_bench;

  localparam int unsigned W = 16;

  logic clk = 1'b0;
  logic power_good = 1'b0;
  logic pin_ref_lvl = 1'b0;
  logic pin_alt_lvl = 1'b0;
  logic oe_ref, oe_alt, strap_ref, strap_fs1, alt_is_24m, done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  strap_sampler #(.WINDOW_CYCLES(W)) u_strap_sampler (
    .clk(clk), .power_good(power_good), .pin_ref_lvl(pin_ref_lvl),
    .pin_alt_lvl(pin_alt_lvl), .oe_ref(oe_ref), .oe_alt(oe_alt),
    .strap_ref(strap_ref), .strap_fs1(strap_fs1), .alt_is_24m(alt_is_24m),
    .done(done)
  );

  function automatic logic exp_done(input int k);
    return k >= int'(W) + 2;
  endfunction

  function automatic logic exp_oe(input int k);
    return k >= int'(W) + 3;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all_zero(input string req);
    chk({oe_ref, oe_alt, done, strap_ref, strap_fs1, alt_is_24m} == 6'b0, req,
        int'({oe_ref, oe_alt, done, strap_ref, strap_fs1, alt_is_24m}), 0);
  endtask

  // Power up with noisy pins that settle to (fr, fa) before edge W.
  // drop_at > 0 drops power_good after that edge.
  task automatic run_pass(input logic fr, input logic fa, input int drop_at, input bit noisy);
    @(negedge clk);
    pin_ref_lvl = $urandom_range(0, 1);
    pin_alt_lvl = $urandom_range(0, 1);
    power_good = 1'b1;
    for (int k = 1; k <= int'(W) + 8; k++) begin
      @(negedge clk);
      if (drop_at == k) begin
        power_good = 1'b0;
        #1;
        chk_all_zero("R6 drop");
        return;
      end
      chk(done == exp_done(k), "R1 done timing", int'(done), int'(exp_done(k)));
      chk({oe_ref, oe_alt} == {2{exp_oe(k)}}, "R2/R4 enables", int'({oe_ref, oe_alt}),
          int'({2{exp_oe(k)}}));
      if (k < int'(W) - 1 && noisy) begin
        pin_ref_lvl = $urandom_range(0, 1);
        pin_alt_lvl = $urandom_range(0, 1);
      end else if (k == int'(W) - 1) begin
        pin_ref_lvl = fr;
        pin_alt_lvl = fa;
      end else if (k >= int'(W) + 2) begin
        pin_ref_lvl = $urandom_range(0, 1);
        pin_alt_lvl = $urandom_range(0, 1);
      end
      if (k >= int'(W) + 2) begin
        chk({strap_ref, strap_fs1} == {fr, fa}, "R3/R5 straps",
            int'({strap_ref, strap_fs1}), int'({fr, fa}));
        chk(alt_is_24m == fr, "R7 rate select", int'(alt_is_24m), int'(fr));
      end
    end
    if (drop_at < 0) begin
      power_good = 1'b0;
      #1;
      chk_all_zero("R6 power loss");
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    pin_ref_lvl = 1'b1;
    pin_alt_lvl = 1'b1;
    @(negedge clk);
    chk_all_zero("R8 before power-up");
    // Directed: all four strap combinations, quiet and noisy
    run_pass(1'b0, 1'b0, -1, 1'b0);
    run_pass(1'b1, 1'b0, -1, 1'b1);
    run_pass(1'b0, 1'b1, -1, 1'b1);
    run_pass(1'b1, 1'b1, 0, 1'b1);
    // Power loss after done while power stayed up: then re-sample differs
    @(negedge clk);
    power_good = 1'b0;
    #1;
    chk_all_zero("R6 clear after done");
    // Drop inside the window, then a full pass with new values
    run_pass(1'b1, 1'b1, int'(W) / 2, 1'b1);
    run_pass(1'b0, 1'b1, -1, 1'b1);
    // Drop exactly at capture and just before drivers enable
    run_pass(1'b1, 1'b0, int'(W) + 1, 1'b1);
    run_pass(1'b1, 1'b0, int'(W) + 2, 1'b1);
    run_pass(1'b1, 1'b0, -1, 1'b1);
    // Random passes
    for (int n = 0; n < 25; n++) begin
      logic r, a;
      int d;
      r = 1'($urandom_range(0, 1));
      a = 1'($urandom_range(0, 1));
      d = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, W + 6)) : -1;
      run_pass(r, a, d, 1'b1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule